// File: doc/BRIEF.md
# Write Bus Cycle Generator

This block runs one processor write cycle on a multiplexed address/data bus. A core-side requester presents a request strobe with an address and a data word while the block is not busy. The block then moves through fixed clock phases. In the first phase it puts the address on the shared bus and pulses the address latch enable. In the next phase it lowers the write strobe and replaces the address with the data word. It then waits for the target's ready input. In the last phase it raises the strobe while the data is still driven.

Every strobe edge is placed a whole number of clocks from the rising edge of the write strobe. This makes the address, chip-select and data setup margins exact clock counts. Wait states make the write pulse and the whole cycle longer. The recovery gap between one write and the next does not change with wait states.

Top module: `wbus_write_gen`

## Requirements
- R1: While reset is asserted and after its release, before any request: busy = 0, ale = 0, cs_n = 1, wr_n = 1, ad_oe = 0.
- R2: When req = 1 is sampled at a rising clock edge while busy = 0, the next clock period is T1. In T1, ale = 1, ad_oe = 1, cs_n = 0, wr_n = 1, and ad_out equals the address sampled with the request.
- R3: A request presented while busy = 1 is ignored. It starts no cycle, it raises no extra ale pulse, and the address and data driven for the running cycle do not change.
- R4: wr_n falls at the start of the clock period that follows T1. From that period on, ad_out carries the write data.
- R5: cs_n is low from the start of T1 to the end of T4. With W wait states it goes low exactly 3+W clocks before wr_n rises.
- R6: Data is valid on the bus (ad_oe = 1, ad_out = data) in every period with wr_n = 0, which is 2+W clocks before wr_n rises. Data stays driven for one clock after wr_n rises, and then ad_oe drops.
- R7: ready is sampled at the end of T3 and at the end of each wait period. Each low sample adds one wait period, so the write pulse lasts 2+W clocks and the cycle (cs_n low) lasts 4+W clocks.
- R8: busy is high in each of the 4+W periods of a cycle and is low in the period that follows T4.
- R9: When requests are presented back to back, the next wr_n falling edge comes exactly 3 clocks after the previous wr_n rising edge, whatever W is.
- R10: ale is high for exactly one clock per cycle. The address is on the bus 3+W clocks before wr_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Write request strobe |
| addr | input | BUS_W | Write address |
| wdata | input | BUS_W | Write data |
| ready | input | 1 | Target ready; low inserts a wait period |
| busy | output | 1 | Cycle in progress; new requests are refused |
| ale | output | 1 | Address latch enable |
| cs_n | output | 1 | Active-low chip select |
| wr_n | output | 1 | Active-low write strobe |
| ad_out | output | BUS_W | Multiplexed address/data value |
| ad_oe | output | 1 | Bus drive enable |

## Verification
All outputs are decoded from the phase register, so each one responds to a stimulus one clock after the edge that samples it. ale appears in the period after an accepted request. wr_n falls one period later. wr_n rises 3+W periods after ale, and cs_n and busy clear 4+W periods after ale. The bench samples every output on the falling clock edge, records the period index of each strobe edge, and compares the differences with these formulas. It drives ready half a period ahead of each sampling edge. While ready is not being sampled, it drives a random value.

// File: rtl/wbus_write_gen.sv
module wbus_write_gen #(
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [BUS_W-1:0] addr,
  input  logic [BUS_W-1:0] wdata,
  input  logic             ready,
  output logic             busy,
  output logic             ale,
  output logic             cs_n,
  output logic             wr_n,
  output logic [BUS_W-1:0] ad_out,
  output logic             ad_oe
);

  typedef enum logic [2:0] {
    PH_IDLE, PH_T1, PH_T2, PH_T3, PH_TW, PH_T4
  } phase_t;

  phase_t           ph, ph_nx;
  logic [BUS_W-1:0] adr_q, dat_q;
  logic             take;
  logic             strobe;

  assign take = (ph == PH_IDLE) && req;

  always_comb begin
    ph_nx = ph;
    case (ph)
      PH_IDLE: if (req) ph_nx = PH_T1;
      PH_T1:   ph_nx = PH_T2;
      PH_T2:   ph_nx = PH_T3;
      PH_T3,
      PH_TW:   ph_nx = ready ? PH_T4 : PH_TW;
      PH_T4:   ph_nx = PH_IDLE;
      default: ph_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      adr_q <= '0;
      dat_q <= '0;
    end else begin
      ph <= ph_nx;
      if (take) begin
        adr_q <= addr;
        dat_q <= wdata;
      end
    end
  end

  assign strobe = (ph == PH_T2) || (ph == PH_T3) || (ph == PH_TW);
  assign busy   = (ph != PH_IDLE);
  assign ale    = (ph == PH_T1);
  assign cs_n   = ~busy;
  assign wr_n   = ~strobe;
  assign ad_oe  = busy;
  assign ad_out = ale ? adr_q : dat_q;

  AST_ALE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> $past(req && !busy));                                   // R2
  AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req) |=> !ale);                                        // R3
  AST_FALL_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> $past(ale));                                    // R4
  AST_STROBE_IN_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (!cs_n && ad_oe));                                    // R5
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> (ad_oe && !cs_n && $stable(ad_out)));           // R6
  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_T3 || ph == PH_TW) && !ready) |=> !wr_n);            // R7
  AST_READY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == PH_T3 || ph == PH_TW) && ready) |=> (wr_n && busy));    // R7
  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |=> !busy);                                         // R8
  AST_SINGLE_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && !wr_n));                                       // R10

endmodule

// File: tb/wbus_write_gen_tb.sv
module wbus_write_gen_tb;
  localparam int BW = 16;

  logic clk = 0, rst_n = 0, req = 0, ready = 0;
  logic [BW-1:0] addr = '0, wdata = '0;
  logic busy, ale, cs_n, wr_n, ad_oe;
  logic [BW-1:0] ad_out;

  wbus_write_gen #(.BUS_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .wdata(wdata),
    .ready(ready), .busy(busy), .ale(ale), .cs_n(cs_n), .wr_n(wr_n),
    .ad_out(ad_out), .ad_oe(ad_oe));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int cyc = 0, lowcnt = 0, wexp = 0;
  int t_ale, t_fall, t_rise, t_cs0, t_cs1, ale_n, busy_n;
  int err_addr, err_dat, err_hold, err_oe;
  logic [BW-1:0] exp_a, exp_d;
  logic prev_wr = 1, prev_cs = 1, done = 0;

  function automatic int f_pulse(int w); return 2 + w; endfunction
  function automatic int f_cycle(int w); return 4 + w; endfunction
  function automatic int f_setup_cs(int w); return 3 + w; endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic clr();
    ale_n = 0; busy_n = 0; err_addr = 0; err_dat = 0; err_hold = 0; err_oe = 0;
    t_ale = -1; t_fall = -1; t_rise = -1; t_cs0 = -1; t_cs1 = -1; done = 0;
  endtask

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (ale) begin
        ale_n++; t_ale = cyc;
        if (ad_out !== exp_a || !ad_oe || cs_n || !wr_n) err_addr++;
      end
      if (busy) busy_n++;
      if (!wr_n && prev_wr) t_fall = cyc;
      if (wr_n && !prev_wr) begin
        t_rise = cyc;
        if (!ad_oe || ad_out !== exp_d) err_hold++;
      end
      if (!wr_n && (!ad_oe || ad_out !== exp_d || cs_n)) err_dat++;
      if (!cs_n && prev_cs) t_cs0 = cyc;
      if (cs_n && !prev_cs) begin
        t_cs1 = cyc; done = 1;
        if (ad_oe) err_oe++;
      end
      lowcnt = !wr_n ? lowcnt + 1 : 0;
    end
    prev_wr = wr_n; prev_cs = cs_n;
    #1 ready = (lowcnt >= 2) ? (lowcnt >= 2 + wexp) : logic'($urandom % 2);
  end

  task automatic check_tx(input int w);
    chk(ale_n == 1, "R10 ale pulses", ale_n, 1);
    chk(err_addr == 0, "R2 address phase", err_addr, 0);
    chk(t_fall == t_ale + 1, "R4 strobe fall offset", t_fall - t_ale, 1);
    chk(t_cs0 == t_ale, "R5 select start", t_cs0 - t_ale, 0);
    chk(t_rise - t_cs0 == f_setup_cs(w), "R5 select setup", t_rise - t_cs0, f_setup_cs(w));
    chk(err_dat == 0 && err_hold == 0, "R6 data valid and hold", err_dat + err_hold, 0);
    chk(t_cs1 - t_rise == 1 && err_oe == 0, "R6 hold one clock", t_cs1 - t_rise, 1);
    chk(t_rise - t_fall == f_pulse(w), "R7 pulse width", t_rise - t_fall, f_pulse(w));
    chk(t_cs1 - t_cs0 == f_cycle(w), "R7 cycle length", t_cs1 - t_cs0, f_cycle(w));
    chk(busy_n == f_cycle(w) && !busy, "R8 busy span", busy_n, f_cycle(w));
    chk(t_rise - t_ale == f_setup_cs(w), "R10 address setup", t_rise - t_ale, f_setup_cs(w));
  endtask

  task automatic one_write(input logic [BW-1:0] a, input logic [BW-1:0] d,
                           input int w, input bit poke);
    @(negedge clk); #2;
    clr(); wexp = w; exp_a = a; exp_d = d;
    req = 1; addr = a; wdata = d;
    @(negedge clk); #2;
    req = 0; addr = ~a; wdata = ~d;
    if (poke) begin
      @(negedge clk); #2;
      req = 1;                                  // R3: request while busy
      @(negedge clk); #2;
      req = 0;
    end
    wait (done);
    check_tx(w);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(ale_n == 1 && !busy, "R3 busy request ignored", ale_n, 1);
    end
  endtask

  initial begin
    int first_rise;
    logic [BW-1:0] a2, d2;
    clr();
    repeat (3) @(negedge clk);
    chk(!busy && !ale && cs_n && wr_n && !ad_oe, "R1 reset state in reset", busy, 0);
    #2 rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy && !ale && cs_n && wr_n && !ad_oe, "R1 idle after reset", busy, 0);

    void'($urandom(32'd1234));
    one_write(16'h1234, 16'hABCD, 0, 0);
    one_write(16'h0F0F, 16'h5A5A, 1, 0);
    one_write(16'hFFFF, 16'h0000, 3, 0);
    one_write(16'h0001, 16'h8000, 2, 1);

    for (int i = 0; i < 20; i++)
      one_write(BW'($urandom), BW'($urandom), int'($urandom % 5), bit'($urandom % 2));

    for (int w = 0; w < 4; w += 3) begin       // R9 back to back
      @(negedge clk); #2;
      clr(); wexp = w; exp_a = 16'h2222; exp_d = 16'h3333;
      req = 1; addr = exp_a; wdata = exp_d;
      wait (done);
      check_tx(w);
      first_rise = t_rise;
      a2 = 16'h4444; d2 = 16'h5555;
      clr(); exp_a = a2; exp_d = d2;
      #1 addr = a2; wdata = d2;
      @(negedge clk); #2;
      req = 0;
      wait (done);
      check_tx(w);
      chk(t_fall - first_rise == 3, "R9 recovery gap", t_fall - first_rise, 3);
    end

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule